// File: doc/BRIEF.md
# Register-Programmed I2C Byte Master

This block is an I2C bus master that software steers one byte at a time. Software first sets four control bits: start, stop, acknowledge-out and enable. It then writes a 32-bit transmit word. That write is the trigger. The control bits latched at that moment decide what the engine does:

- a start (or repeated start) followed by an address byte,
- a plain data byte sent to the slave,
- a received byte, answered with ACK or NACK,
- a stop condition.

Software polls the complete, acknowledge-in and data-in flags between operations and reads received bytes from the receive data output.

Both bus lines are open-drain, modelled as "pull low" enables. The SCL period is four quarter-periods, and each quarter-period lasts `QTR_DIV` clock cycles. After a start the master keeps SCL low between operations. A later start therefore produces a repeated start, and only a stop releases the bus. Arbitration, clock stretching, slave mode and interrupts are not part of the block.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the complete flag `st_done` is 1 and both line enables are 0. An accepted transmit write clears `st_done` on the next clock edge, and `st_done` stays 0 while an operation runs.
- R2: With control bits start and enable set (`ctrl_wdata` bit 3 = start, bit 1 = ack-out, bit 0 = enable, bit 2 = stop), a transmit write issues a start condition and then the byte {`tx_wdata[30:24]`, `tx_wdata[31]`}. It is sent MSB first, so the 7-bit address (bit 30 first) precedes the read/write flag (1 = read). If the bus is already held, the start is a repeated start.
- R3: A start operation takes 40 quarter-periods (4 for the start, 36 for nine bit slots). A byte operation takes 36 quarter-periods. A stop takes 4 quarter-periods. Each quarter-period is `QTR_DIV` clocks, counted from the accepted write to `st_done` rising.
- R4: `st_ack_in` is 1 exactly when the slave held SDA low in the acknowledge slot of the last transmitted byte.
- R5: With only enable set after a read address, a transmit write receives one byte. The written data is ignored and SDA is released for the 8 data bits. The byte is assembled MSB first onto `rx_data`, and `st_din` sets when the byte completes.
- R6: In a received byte's acknowledge slot the master pulls SDA low (ACK) if ack-out was set, and releases it (NACK) otherwise.
- R7: With stop and enable set, a transmit write drives SDA high while SCL is high, then releases both lines and sets `st_done`. The written data is ignored.
- R8: A transmit write while enable is clear is ignored: `st_done` stays 1 and both lines stay released.
- R9: SDA changes while SCL is released only inside a start or stop sequence.
- R10: `st_din` clears on every accepted transmit write and sets only at the end of a received byte.
- R11: A transmit write while an operation is running is ignored and does not alter that operation.
- R12: When a non-read byte is sent after a write address, it is `tx_wdata[31:24]`, bit 31 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 4 | Control value: [3] start, [2] stop, [1] ack-out, [0] enable |
| tx_wr | input | 1 | Write strobe for the transmit register; starts an operation |
| tx_wdata | input | 32 | Transmit word; byte lane [31:24] is used |
| sda_in | input | 1 | Sensed SDA line level |
| rx_data | output | 8 | Last received byte |
| st_done | output | 1 | Operation complete flag |
| st_ack_in | output | 1 | Slave acknowledged last transmitted byte |
| st_din | output | 1 | A received byte is available |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench sweeps several byte values through a modelled slave that decodes the bus from the line levels alone. Data driven while SCL is high would show up there as extra starts or stops, and a wrong bit order would show up as corrupted written bytes. Reads use an all-zero dummy word, so an engine that shifts the written data instead of releasing SDA returns zeros rather than the slave's bytes. The last byte of a sequential read must be NACKed; an engine that ignored ack-out would make the slave keep sending. Writes with enable clear, writes during a running operation, and a wrong address (which must leave acknowledge-in at 0) are each checked, and operation lengths are compared cycle-exactly.

// File: rtl/i2c_bm_pkg.sv
`timescale 1ns/1ps
package i2c_bm_pkg;

    typedef struct packed {
        logic start;
        logic stop;
        logic ack_out;
        logic enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BITS  = 2'd2,
        PH_STOP  = 2'd3
    } phase_t;

endpackage

// File: rtl/i2c_bm_qtick.sv
`timescale 1ns/1ps
module i2c_bm_qtick #(
    parameter int QTR_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_bm_engine.sv
`timescale 1ns/1ps
module i2c_bm_engine
    import i2c_bm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  ctrl_t             op_ctrl,
    input  logic [BYTE_W-1:0] op_byte,
    input  logic              sda_in,
    output logic              busy,
    output logic              held,
    output phase_t            phase,
    output logic              done,
    output logic              ack_in,
    output logic              din,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_low,
    output logic              sda_low
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(BYTE_W);
    localparam logic [1:0] Q_SAMPLE = 2'd1;
    localparam logic [1:0] Q_LAST   = 2'd3;

    typedef struct packed {
        phase_t            phase;
        logic [1:0]        qstep;
        logic [BCW-1:0]    bitn;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rxsh;
        logic [BYTE_W-1:0] rx_byte;
        logic              rd_mode;
        logic              rd_op;
        logic              ack_out;
        logic              held;
        logic              done;
        logic              ack_in;
        logic              din;
    } st_t;

    st_t q, d;
    logic bit_val;

    always_comb begin
        d = q;
        if (go) begin
            d.done    = 1'b0;
            d.din     = 1'b0;
            d.qstep   = 2'd0;
            d.bitn    = '0;
            d.ack_out = op_ctrl.ack_out;
            if (op_ctrl.stop) begin
                d.phase = PH_STOP;
            end else if (op_ctrl.start) begin
                d.phase   = PH_START;
                d.rd_mode = op_byte[BYTE_W-1];
                d.rd_op   = 1'b0;
                d.shreg   = {op_byte[BYTE_W-2:0], op_byte[BYTE_W-1]};
            end else begin
                d.phase = PH_BITS;
                d.rd_op = q.rd_mode;
                d.shreg = q.rd_mode ? '1 : op_byte;
            end
        end else if (tick) begin
            d.qstep = q.qstep + 2'd1;
            unique case (q.phase)
                PH_START: begin
                    if (q.qstep == Q_LAST) begin
                        d.phase = PH_BITS;
                        d.held  = 1'b1;
                    end
                end
                PH_BITS: begin
                    if (q.qstep == Q_SAMPLE) begin
                        if (q.bitn != ACK_SLOT) d.rxsh = {q.rxsh[BYTE_W-2:0], sda_in};
                        else if (!q.rd_op)      d.ack_in = !sda_in;
                    end
                    if (q.qstep == Q_LAST) begin
                        if (q.bitn == ACK_SLOT) begin
                            d.phase = PH_IDLE;
                            d.done  = 1'b1;
                            if (q.rd_op) begin
                                d.din     = 1'b1;
                                d.rx_byte = q.rxsh;
                            end
                        end else begin
                            d.bitn  = q.bitn + BCW'(1);
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b1};
                        end
                    end
                end
                PH_STOP: begin
                    if (q.qstep == Q_LAST) begin
                        d.phase = PH_IDLE;
                        d.held  = 1'b0;
                        d.done  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.done  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // Line decode from registered state
    always_comb begin
        bit_val = (q.bitn == ACK_SLOT) ? (q.rd_op ? !q.ack_out : 1'b1) : q.shreg[BYTE_W-1];
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                scl_low = q.held;
            end
            PH_START: begin
                scl_low = (q.qstep == 2'd0) ? q.held : (q.qstep == Q_LAST);
                sda_low = q.qstep[1];
            end
            PH_BITS: begin
                scl_low = (q.qstep == 2'd0) || (q.qstep == Q_LAST);
                sda_low = !bit_val;
            end
            PH_STOP: begin
                scl_low = (q.qstep == 2'd0);
                sda_low = !q.qstep[1];
            end
            default: ;
        endcase
    end

    assign busy    = (q.phase != PH_IDLE);
    assign held    = q.held;
    assign phase   = q.phase;
    assign done    = q.done;
    assign ack_in  = q.ack_in;
    assign din     = q.din;
    assign rx_byte = q.rx_byte;
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int QTR_DIV = 8,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [3:0]        ctrl_wdata,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              sda_in,
    output logic [7:0]        rx_data,
    output logic              st_done,
    output logic              st_ack_in,
    output logic              st_din,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int BYTE_W = 8;
    localparam int LANE   = WORD_W - BYTE_W;

    ctrl_t  ctrl_d, ctrl_q;
    logic   go, tick, eng_busy, eng_held, ctrl_en;
    phase_t eng_phase;
    logic   unused_low_lanes;

    assign unused_low_lanes = ^tx_wdata[LANE-1:0];

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) ctrl_d = ctrl_t'(ctrl_wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_en = ctrl_q.enable;
    assign go      = tx_wr && ctrl_en && !eng_busy;

    i2c_bm_qtick #(.QTR_DIV(QTR_DIV)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .tick (tick)
    );

    i2c_bm_engine #(.BYTE_W(BYTE_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .go     (go),
        .op_ctrl(ctrl_q),
        .op_byte(tx_wdata[WORD_W-1:LANE]),
        .sda_in (sda_in),
        .busy   (eng_busy),
        .held   (eng_held),
        .phase  (eng_phase),
        .done   (st_done),
        .ack_in (st_ack_in),
        .din    (st_din),
        .rx_byte(rx_data),
        .scl_low(scl_oe),
        .sda_low(sda_oe)
    );
endmodule

// File: rtl/i2c_bm_chk.sv
`timescale 1ns/1ps
module i2c_bm_chk
    import i2c_bm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   tx_wr,
    input logic   enable,
    input logic   busy,
    input logic   held,
    input phase_t phase,
    input logic   done,
    input logic   din,
    input logic   scl_oe,
    input logic   sda_oe
);
    // R1
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && enable && !busy) |=> !done);

    // R1
    done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R8
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !enable && !busy) |=> ($stable(done) && !busy));

    // R9
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
            |-> (phase == PH_START || phase == PH_STOP));

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !held) |-> (!scl_oe && !sda_oe));

    // R10
    din_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(din) |-> (done && !busy));
endmodule

bind i2c_byte_master i2c_bm_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_wr (tx_wr),
    .enable(ctrl_en),
    .busy  (eng_busy),
    .held  (eng_held),
    .phase (eng_phase),
    .done  (st_done),
    .din   (st_din),
    .scl_oe(scl_oe),
    .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
    localparam int Q = 3;
    localparam logic [6:0] SLV = 7'h52;
    localparam logic [3:0] C_OFF = 4'b0000, C_EN = 4'b0001, C_ACK = 4'b0011,
                           C_STA = 4'b1001, C_STA_ACK = 4'b1011, C_STP = 4'b0101;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctrl_wr = 1'b0, tx_wr = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic [31:0] tx_wdata = '0;
    logic [7:0] rx_data;
    logic st_done, st_ack_in, st_din, scl_oe, sda_oe;
    logic slv_pull = 1'b0;
    wire  sda_line = !(sda_oe || slv_pull);

    always #2.5 clk = ~clk;

    i2c_byte_master #(.QTR_DIV(Q)) u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .sda_in(sda_line), .rx_data(rx_data),
        .st_done(st_done), .st_ack_in(st_ack_in), .st_din(st_din),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    // ---------------- slave model from line levels ----------------
    logic scl_l, sda_l, scl_p, sda_p, mack, last_mack, first;
    logic [7:0] sh, txb, ptr;
    logic [7:0] wlog [0:7];
    int pos, sph, wcnt, starts, stops;

    always @(posedge clk) begin
        scl_l = !scl_oe;
        sda_l = sda_line;
        if (!rst_n) begin
            pos = 0; sph = 0; wcnt = 0; starts = 0; stops = 0;
            sh = '0; txb = '0; ptr = '0; mack = 1'b0; last_mack = 1'b0; first = 1'b0;
            slv_pull <= 1'b0;
            scl_l = 1'b1; sda_l = 1'b1;
        end else if (scl_l && scl_p && !sda_l && sda_p) begin
            starts = starts + 1; sph = 1; pos = 0; slv_pull <= 1'b0;
        end else if (scl_l && scl_p && sda_l && !sda_p) begin
            stops = stops + 1; sph = 0; pos = 0; slv_pull <= 1'b0;
        end else if (scl_l && !scl_p) begin
            if (pos < 8 && (sph == 1 || sph == 2)) sh = {sh[6:0], sda_l};
            if (pos == 8 && sph == 3) mack = !sda_l;
            pos = pos + 1;
        end else if (!scl_l && scl_p) begin
            if (pos == 8) begin
                if (sph == 1)      slv_pull <= (sh[7:1] == SLV);
                else if (sph == 2) slv_pull <= 1'b1;
                else               slv_pull <= 1'b0;
            end else if (pos == 9) begin
                pos = 0;
                slv_pull <= 1'b0;
                if (sph == 1) begin
                    if (sh[7:1] != SLV) sph = 0;
                    else if (sh[0]) begin sph = 3; txb = mem_val(ptr); slv_pull <= !txb[7]; end
                    else begin sph = 2; first = 1'b1; end
                end else if (sph == 2) begin
                    if (first) begin ptr = sh; first = 1'b0; end
                    else if (wcnt < 8) begin wlog[wcnt] = sh; wcnt = wcnt + 1; end
                end else if (sph == 3) begin
                    ptr = ptr + 8'd1;
                    last_mack = mack;
                    if (mack) begin txb = mem_val(ptr); slv_pull <= !txb[7]; end
                    else sph = 0;
                end
            end else if (pos >= 1 && pos <= 7 && sph == 3) begin
                slv_pull <= !txb[7 - pos];
            end
        end
        scl_p = scl_l;
        sda_p = sda_l;
    end

    // ---------------- checking ----------------
    int nchk = 0, nerr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [3:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic do_tx(input logic [31:0] v, output int n, output logic early_done);
        tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk);
        tx_wr = 1'b0;
        early_done = st_done;
        n = 0;
        while (!st_done && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic ed;
        logic [7:0] wdat [0:5];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(st_done == 1'b1, "R1 reset done", 32'(st_done), 1);
        chk(!scl_oe && !sda_oe, "R1 reset lines", {30'd0, scl_oe, sda_oe}, 0);
        chk(st_din == 1'b0, "R10 reset din", 32'(st_din), 0);

        // R8 disabled write ignored
        set_ctrl(C_OFF);
        tx_wr = 1'b1; tx_wdata = {1'b0, SLV, 24'h0};
        @(negedge clk);
        tx_wr = 1'b0;
        chk(st_done == 1'b1, "R8 done stays", 32'(st_done), 1);
        repeat (4 * Q) begin
            @(negedge clk);
            if (scl_oe || sda_oe) chk(1'b0, "R8 lines released", {30'd0, scl_oe, sda_oe}, 0);
        end
        chk(starts == 0, "R8 no bus activity", 32'(starts), 0);

        // Write transaction: address, word pointer, six data bytes
        set_ctrl(C_STA);
        do_tx({1'b0, SLV, 24'h0}, n, ed);
        chk(ed == 1'b0, "R1 done cleared", 32'(ed), 0);
        chk(n == 40 * Q, "R3 start op length", 32'(n), 32'(40 * Q));
        chk(st_ack_in == 1'b1, "R4 address acked", 32'(st_ack_in), 1);
        chk(starts == 1, "R2 start seen", 32'(starts), 1);
        set_ctrl(C_EN);
        do_tx({8'h10, 24'hABCDEF}, n, ed);
        chk(n == 36 * Q, "R3 byte op length", 32'(n), 32'(36 * Q));
        chk(ptr == 8'h10, "R12 pointer byte", 32'(ptr), 32'h10);
        for (int i = 0; i < 6; i++) begin
            wdat[i] = 8'(i * 53 + 7);
            do_tx({wdat[i], 24'h0}, n, ed);
            chk(st_ack_in == 1'b1, "R4 data acked", 32'(st_ack_in), 1);
            chk(n == 36 * Q, "R3 data op length", 32'(n), 32'(36 * Q));
        end
        set_ctrl(C_STP);
        do_tx(32'h0, n, ed);
        chk(n == 4 * Q, "R3 stop op length", 32'(n), 32'(4 * Q));
        chk(stops == 1, "R7 stop seen", 32'(stops), 1);
        chk(!scl_oe && !sda_oe, "R7 lines released", {30'd0, scl_oe, sda_oe}, 0);
        chk(wcnt == 6, "R12 byte count", 32'(wcnt), 6);
        for (int i = 0; i < 6; i++)
            chk(wlog[i] == wdat[i], "R12 written byte", 32'(wlog[i]), 32'(wdat[i]));

        // Sequential read with repeated start
        set_ctrl(C_STA);
        do_tx({1'b0, SLV, 24'h0}, n, ed);
        set_ctrl(C_EN);
        do_tx({8'h20, 24'h0}, n, ed);
        set_ctrl(C_STA_ACK);
        do_tx({1'b1, SLV, 24'h0}, n, ed);
        chk(starts == 3, "R2 repeated start", 32'(starts), 3);
        chk(st_ack_in == 1'b1, "R4 read address acked", 32'(st_ack_in), 1);
        chk(st_din == 1'b0, "R10 din after address", 32'(st_din), 0);
        for (int i = 0; i < 5; i++) begin
            set_ctrl((i == 4) ? C_EN : C_ACK);
            do_tx(32'h0, n, ed);
            chk(st_din == 1'b1, "R5 din set", 32'(st_din), 1);
            chk(rx_data == mem_val(8'(8'h20 + i)), "R5 read byte", 32'(rx_data), 32'(mem_val(8'(8'h20 + i))));
            chk(n == 36 * Q, "R3 read op length", 32'(n), 32'(36 * Q));
            chk(last_mack == (i != 4), "R6 master ack", 32'(last_mack), 32'(i != 4));
        end
        set_ctrl(C_STP);
        do_tx(32'h0, n, ed);
        chk(st_din == 1'b0, "R10 din cleared", 32'(st_din), 0);
        chk(stops == 2, "R7 stop after read", 32'(stops), 2);
        chk(sph == 0, "R6 slave released after NACK", 32'(sph), 0);

        // Wrong address not acknowledged
        set_ctrl(C_STA);
        do_tx({1'b0, SLV ^ 7'h01, 24'h0}, n, ed);
        chk(st_ack_in == 1'b0, "R4 no ack", 32'(st_ack_in), 0);
        set_ctrl(C_STP);
        do_tx(32'h0, n, ed);

        // R11 write during a running operation
        set_ctrl(C_STA);
        tx_wr = 1'b1; tx_wdata = {1'b0, SLV, 24'h0};
        @(negedge clk);
        tx_wr = 1'b0;
        n = 0;
        while (!st_done && n < 10000) begin
            if (n == 5) begin tx_wr = 1'b1; tx_wdata = {1'b0, SLV ^ 7'h02, 24'h0}; end
            else tx_wr = 1'b0;
            @(negedge clk);
            n++;
        end
        tx_wr = 1'b0;
        chk(n == 40 * Q, "R11 length unchanged", 32'(n), 32'(40 * Q));
        chk(st_ack_in == 1'b1, "R11 original address kept", 32'(st_ack_in), 1);
        set_ctrl(C_STP);
        do_tx(32'h0, n, ed);
        chk(starts == 5, "R9 no spurious start", 32'(starts), 5);
        chk(stops == 4, "R9 no spurious stop", 32'(stops), 4);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule